// File: doc/BRIEF.md
# Per-Channel Display Gamma Lookup

This block is the gamma correction stage of a display pixel pipeline. Each incoming pixel carries an 8-bit red, green and blue component, and each component is replaced by the entry it indexes in a 256-entry table of its own. The pixel path always registers its output once, so the output lags the input by one clock. The valid, horizontal sync, vertical sync and blank markers that travel with the pixel are delayed by the same amount. When correction is switched off, components pass through unchanged with the same one-clock delay, so toggling correction never moves the output timing.

Software loads and reads back the three tables through a simple word-wide register port that also holds a control word. Table access is only honoured while correction is off or while the timing generator signals vertical blanking. This way active scan-out never reads a table that is half rewritten. An access outside that window has no effect on the tables, returns zero if it is a read, and raises a sticky error flag that software clears by writing a one to it.

Top module: `gamma_lut_stage`

## Requirements
- R1: After reset, correction is off, the error flag is 0, `bus_rvalid_o` is 0 and every pixel output is 0. The table contents are undefined until software writes them.
- R2: With correction off, each output component equals the matching input component from one clock earlier.
- R3: With correction on, each output component equals the entry of its own channel's table that the input component, sampled one clock earlier, indexes. Vertical blanking does not affect the pixel path.
- R4: `pix_valid_o`, `hsync_o`, `vsync_o` and `blank_o` equal their inputs from one clock earlier, whether correction is on or off.
- R5: `bus_addr_i[11:10]` selects the region: 0 is the red table (0x000), 1 is the green table (0x400), 2 is the blue table (0x800) and 3 is the control word (0xC00). Within a table, the entry index is `bus_addr_i[9:2]` (4-byte stride), and `bus_addr_i[1:0]` is ignored.
- R6: A table write stores only `bus_wdata_i[7:0]`, which is byte 0 of the little-endian word. A read request raises `bus_rvalid_o` on the next clock, with the entry zero-extended to 32 bits on `bus_rdata_o`.
- R7: Table access is honoured on any cycle where `vblank_i` is 1 or correction is off.
- R8: A table access outside that window leaves the tables unchanged. If it is a read, it returns 0. In both cases it sets the error flag.
- R9: Control word: bit 2 is the correction enable (read/write) and bit 8 is the error flag. The flag stays at 1 until a control write with bit 8 set clears it. A control write with bit 8 clear leaves the flag unchanged. Control accesses are always honoured and never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vblank_i | input | 1 | Vertical blanking from the timing generator |
| bus_req_i | input | 1 | Register access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address inside the gamma window |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid, one clock after a read request |
| bus_rdata_o | output | 32 | Read data |
| pix_valid_i | input | 1 | Input pixel valid |
| hsync_i | input | 1 | Input horizontal sync |
| vsync_i | input | 1 | Input vertical sync |
| blank_i | input | 1 | Input blank marker |
| red_i | input | 8 | Input red component |
| grn_i | input | 8 | Input green component |
| blu_i | input | 8 | Input blue component |
| pix_valid_o | output | 1 | Delayed valid |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |
| blank_o | output | 1 | Delayed blank marker |
| red_o | output | 8 | Corrected red |
| grn_o | output | 8 | Corrected green |
| blu_o | output | 8 | Corrected blue |

## Verification
The three tables are loaded with different curves: a descending ramp, an XOR pattern and an odd-step ramp. These curves make it visible if channels are swapped, indices are shifted, or one channel's table is applied to another. Pixel streams with varying sync and blank markers, including components 0 and 255, are run in bypass and in corrected mode. The results separate pass-through from lookup and show the one-clock alignment of the markers.

Accesses are tried with correction on and blanking low, which must be blocked. They are repeated with blanking high and with correction off, which must be honoured. A pixel that reads the targeted entry shows whether a blocked write really left the table untouched. The error flag is checked through a set, a write of 0 and a write-one clear.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int unsigned CHANNELS = 3;
  localparam int unsigned EN_BIT   = 2;
  localparam int unsigned ERR_BIT  = 8;
  localparam logic [1:0]  SEL_CTRL = 2'd3;

  typedef struct packed {
    logic valid;
    logic hsync;
    logic vsync;
    logic blank;
  } pix_flags_t;
endpackage

// File: rtl/gamma_table.sv
module gamma_table #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  bus_idx,
  output logic [DATA_W-1:0] bus_q,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [DATA_W-1:0] pix_q
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // storage has no reset: contents are loaded by software
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign bus_q = mem[bus_idx];
  assign pix_q = mem[pix_idx];
endmodule

// File: rtl/gamma_bus_ctrl.sv
module gamma_bus_ctrl
  import gamma_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             vblank_i,
  input  logic                             req_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [BUS_W-1:0]                 wdata_i,
  input  logic [CHANNELS-1:0][DATA_W-1:0]  tbl_q_i,
  output logic [CHANNELS-1:0]              tbl_we_o,
  output logic [IDX_W-1:0]                 tbl_idx_o,
  output logic [DATA_W-1:0]                tbl_wdata_o,
  output logic                             rvalid_o,
  output logic [BUS_W-1:0]                 rdata_o,
  output logic                             gamma_en_o,
  output logic                             err_o
);
  localparam int unsigned SEL_LSB = IDX_W + 2;

  logic [1:0]       sel;
  logic             is_ctrl;
  logic             open_win;
  logic             en_q, en_d;
  logic             err_q, err_d;
  logic             rvalid_q, rvalid_d;
  logic [BUS_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] sel_q;

  assign sel         = addr_i[SEL_LSB +: 2];
  assign is_ctrl     = (sel == SEL_CTRL);
  assign open_win    = vblank_i | ~en_q;
  assign tbl_idx_o   = addr_i[2 +: IDX_W];
  assign tbl_wdata_o = wdata_i[DATA_W-1:0];

  for (genvar c = 0; c < CHANNELS; c++) begin : g_we
    assign tbl_we_o[c] = req_i & we_i & open_win & (sel == 2'(c));
  end

  always_comb begin
    sel_q = '0;
    for (int c = 0; c < CHANNELS; c++) begin
      if (sel == 2'(c)) sel_q = tbl_q_i[c];
    end
  end

  always_comb begin
    en_d     = en_q;
    err_d    = err_q;
    rdata_d  = '0;
    rvalid_d = req_i & ~we_i;
    if (req_i) begin
      if (is_ctrl) begin
        if (we_i) begin
          en_d = wdata_i[EN_BIT];
          if (wdata_i[ERR_BIT]) err_d = 1'b0;
        end else begin
          rdata_d[EN_BIT]  = en_q;
          rdata_d[ERR_BIT] = err_q;
        end
      end else if (!open_win) begin
        err_d = 1'b1;
      end else if (!we_i) begin
        rdata_d = BUS_W'(sel_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      err_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      en_q     <= en_d;
      err_q    <= err_d;
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rvalid_o   = rvalid_q;
  assign rdata_o    = rdata_q;
  assign gamma_en_o = en_q;
  assign err_o      = err_q;
endmodule

// File: rtl/gamma_pix_reg.sv
module gamma_pix_reg
  import gamma_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            gamma_en_i,
  input  pix_flags_t                      flags_i,
  input  logic [CHANNELS-1:0][DATA_W-1:0] pix_i,
  input  logic [CHANNELS-1:0][DATA_W-1:0] lut_i,
  output pix_flags_t                      flags_o,
  output logic [CHANNELS-1:0][DATA_W-1:0] pix_o
);
  logic [CHANNELS-1:0][DATA_W-1:0] pix_d, pix_q;
  pix_flags_t                      flags_q;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_sel
    assign pix_d[c] = gamma_en_i ? lut_i[c] : pix_i[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q   <= '0;
      flags_q <= '0;
    end else begin
      pix_q   <= pix_d;
      flags_q <= flags_i;
    end
  end

  assign pix_o   = pix_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/gamma_lut_stage.sv
module gamma_lut_stage
  import gamma_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vblank_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic              bus_rvalid_o,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic              pix_valid_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              blank_i,
  input  logic [DATA_W-1:0] red_i,
  input  logic [DATA_W-1:0] grn_i,
  input  logic [DATA_W-1:0] blu_i,
  output logic              pix_valid_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              blank_o,
  output logic [DATA_W-1:0] red_o,
  output logic [DATA_W-1:0] grn_o,
  output logic [DATA_W-1:0] blu_o
);
  logic                            gamma_en;
  logic                            err_flag;
  logic [CHANNELS-1:0]             tbl_we;
  logic [IDX_W-1:0]                tbl_idx;
  logic [DATA_W-1:0]               tbl_wdata;
  logic [CHANNELS-1:0][DATA_W-1:0] tbl_bus_q;
  logic [CHANNELS-1:0][DATA_W-1:0] tbl_pix_q;
  logic [CHANNELS-1:0][DATA_W-1:0] pix_in;
  logic [CHANNELS-1:0][DATA_W-1:0] pix_out;
  pix_flags_t                      flags_in, flags_out;

  assign pix_in[0] = red_i;
  assign pix_in[1] = grn_i;
  assign pix_in[2] = blu_i;
  assign flags_in  = '{valid: pix_valid_i, hsync: hsync_i, vsync: vsync_i, blank: blank_i};

  gamma_bus_ctrl #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .vblank_i(vblank_i),
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .tbl_q_i(tbl_bus_q), .tbl_we_o(tbl_we), .tbl_idx_o(tbl_idx), .tbl_wdata_o(tbl_wdata),
    .rvalid_o(bus_rvalid_o), .rdata_o(bus_rdata_o),
    .gamma_en_o(gamma_en), .err_o(err_flag)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_tbl
    gamma_table #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_tbl (
      .clk(clk), .wr_en(tbl_we[c]), .wr_idx(tbl_idx), .wr_data(tbl_wdata),
      .bus_idx(tbl_idx), .bus_q(tbl_bus_q[c]),
      .pix_idx(pix_in[c][IDX_W-1:0]), .pix_q(tbl_pix_q[c])
    );
  end

  gamma_pix_reg #(.DATA_W(DATA_W)) u_pix (
    .clk(clk), .rst_n(rst_n), .gamma_en_i(gamma_en),
    .flags_i(flags_in), .pix_i(pix_in), .lut_i(tbl_pix_q),
    .flags_o(flags_out), .pix_o(pix_out)
  );

  assign red_o       = pix_out[0];
  assign grn_o       = pix_out[1];
  assign blu_o       = pix_out[2];
  assign pix_valid_o = flags_out.valid;
  assign hsync_o     = flags_out.hsync;
  assign vsync_o     = flags_out.vsync;
  assign blank_o     = flags_out.blank;
endmodule

// File: rtl/gamma_lut_stage_chk.sv
module gamma_lut_stage_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vblank_i,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [BUS_W-1:0]  bus_wdata_i,
  input logic              bus_rvalid_o,
  input logic [BUS_W-1:0]  bus_rdata_o,
  input logic              pix_valid_i,
  input logic              hsync_i,
  input logic              vsync_i,
  input logic              blank_i,
  input logic [DATA_W-1:0] red_i,
  input logic              pix_valid_o,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              blank_o,
  input logic [DATA_W-1:0] red_o,
  input logic              gamma_en,
  input logic              err_flag
);
  localparam int unsigned SEL_LSB = IDX_W + 2;

  logic armed;
  logic tbl_acc, blocked, err_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign tbl_acc = bus_req_i && (bus_addr_i[SEL_LSB +: 2] != 2'd3);
  assign blocked = tbl_acc && gamma_en && !vblank_i;
  assign err_clr = bus_req_i && bus_we_i && (bus_addr_i[SEL_LSB +: 2] == 2'd3) && bus_wdata_i[8];

  // R2
  bypass_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(gamma_en) |-> red_o == $past(red_i));

  // R4
  marker_delay_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(pix_valid_i) == pix_valid_o && $past(hsync_i) == hsync_o &&
    $past(vsync_i) == vsync_o && $past(blank_i) == blank_o);

  // R6
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(bus_req_i && !bus_we_i) == bus_rvalid_o);

  // R8
  blocked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(blocked && !bus_we_i) |-> bus_rdata_o == '0);

  // R8
  blocked_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(blocked) |-> err_flag);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(err_flag) && !$past(err_clr)) |-> err_flag);
endmodule

bind gamma_lut_stage gamma_lut_stage_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vblank_i(vblank_i),
  .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .bus_rvalid_o(bus_rvalid_o), .bus_rdata_o(bus_rdata_o),
  .pix_valid_i(pix_valid_i), .hsync_i(hsync_i), .vsync_i(vsync_i), .blank_i(blank_i),
  .red_i(red_i), .pix_valid_o(pix_valid_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
  .blank_o(blank_o), .red_o(red_o), .gamma_en(gamma_en), .err_flag(err_flag)
);

// File: tb/sim_gamma_lut_stage.sv
module sim_gamma_lut_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vblank_i = 1'b0;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic        bus_rvalid_o;
  logic [31:0] bus_rdata_o;
  logic        pix_valid_i = 1'b0, hsync_i = 1'b0, vsync_i = 1'b0, blank_i = 1'b0;
  logic [7:0]  red_i = '0, grn_i = '0, blu_i = '0;
  logic        pix_valid_o, hsync_o, vsync_o, blank_o;
  logic [7:0]  red_o, grn_o, blu_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int stamp;
    logic [7:0] r, g, b;
    logic h, vs, bl;
    string req;
  } exp_t;
  exp_t q[$];

  logic [7:0] mdl [3][256];
  bit mdl_en = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gamma_lut_stage u0 (
    .clk(clk), .rst_n(rst_n), .vblank_i(vblank_i),
    .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rvalid_o(bus_rvalid_o), .bus_rdata_o(bus_rdata_o),
    .pix_valid_i(pix_valid_i), .hsync_i(hsync_i), .vsync_i(vsync_i), .blank_i(blank_i),
    .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i),
    .pix_valid_o(pix_valid_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o),
    .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk); #1;
    bus_req_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    @(posedge clk); #1;
    bus_req_i = 1'b0;
    chk("R6 rvalid", {31'b0, bus_rvalid_o}, 32'd1);
    d = bus_rdata_o;
  endtask

  // driver: applies one pixel and records what must come out one clock later
  task automatic drive_pix(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                           input logic h, input logic vs, input logic bl);
    exp_t e;
    @(posedge clk); #1;
    pix_valid_i = 1'b1; red_i = r; grn_i = g; blu_i = b;
    hsync_i = h; vsync_i = vs; blank_i = bl;
    e.stamp = cyc;
    e.r = mdl_en ? mdl[0][r] : r;
    e.g = mdl_en ? mdl[1][g] : g;
    e.b = mdl_en ? mdl[2][b] : b;
    e.h = h; e.vs = vs; e.bl = bl;
    e.req = mdl_en ? "R3" : "R2";
    q.push_back(e);
  endtask

  task automatic idle_pix();
    @(posedge clk); #1;
    pix_valid_i = 1'b0; hsync_i = 1'b0; vsync_i = 1'b0; blank_i = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  // monitor: compares every valid output pixel against the queue head
  always @(negedge clk) begin
    if (rst_n && pix_valid_o && !done) begin
      if (q.size() == 0) begin
        chk("R4 unexpected valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.req, " red"}, {24'b0, red_o}, {24'b0, e.r});
        chk({e.req, " green"}, {24'b0, grn_o}, {24'b0, e.g});
        chk({e.req, " blue"}, {24'b0, blu_o}, {24'b0, e.b});
        chk("R4 markers", {29'b0, hsync_o, vsync_o, blank_o}, {29'b0, e.h, e.vs, e.bl});
        chk("R4 latency", cyc, e.stamp + 1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 rvalid", {31'b0, bus_rvalid_o}, 32'd0);
    chk("R1 pixel outputs", {4'b0, pix_valid_o, hsync_o, vsync_o, blank_o, red_o, grn_o, blu_o}, 32'd0);
    rst_n = 1'b1;
    bus_read(12'hC00, rd);
    chk("R1 control after reset", rd, 32'h0);

    // load all tables with correction off (R5, R6, R7)
    for (int i = 0; i < 256; i++) begin
      mdl[0][i] = 8'(255 - i);
      mdl[1][i] = 8'(i) ^ 8'h5A;
      mdl[2][i] = 8'(i * 7 + 3);
    end
    for (int c = 0; c < 3; c++) begin
      for (int i = 0; i < 256; i++) begin
        bus_write(12'(c * 1024 + i * 4), {16'hDEAD, 8'(i), mdl[c][i]});
      end
    end
    for (int c = 0; c < 3; c++) begin
      bus_read(12'(c * 1024), rd);
      chk("R5 R6 readback index 0", rd, {24'b0, mdl[c][0]});
      bus_read(12'(c * 1024 + 255 * 4 + 3), rd);
      chk("R5 R6 readback index 255, low bits ignored", rd, {24'b0, mdl[c][255]});
      bus_read(12'(c * 1024 + 77 * 4), rd);
      chk("R5 R6 readback index 77", rd, {24'b0, mdl[c][77]});
    end

    // bypass stream (R2, R4)
    for (int i = 0; i < 16; i++)
      drive_pix(8'(i * 17), 8'(255 - i * 3), 8'(i * 29), i[0], i[1], i[2]);
    drive_pix(8'd0, 8'd255, 8'd0, 1'b1, 1'b1, 1'b1);
    idle_pix();

    // enable correction (R9 bit 2) and run a corrected stream (R3, R4)
    bus_write(12'hC00, 32'h4);
    mdl_en = 1;
    bus_read(12'hC00, rd);
    chk("R9 enable bit reads back", rd, 32'h4);
    for (int i = 0; i < 20; i++)
      drive_pix(8'(i * 13), 8'(i * 11 + 1), 8'(255 - i * 5), i[1], i[0], i[3]);
    drive_pix(8'd255, 8'd0, 8'd255, 1'b0, 1'b1, 1'b0);
    drive_pix(8'd5, 8'd5, 8'd5, 1'b0, 1'b0, 1'b0);
    idle_pix();

    // blocked accesses: enabled, no blanking (R8)
    bus_write(12'h014, 32'h11);
    bus_read(12'hC00, rd);
    chk("R8 R9 error set by blocked write", rd, 32'h104);
    bus_read(12'h014, rd);
    chk("R8 blocked read returns zero", rd, 32'h0);
    drive_pix(8'd5, 8'd9, 8'd9, 1'b0, 1'b0, 1'b0);
    idle_pix();

    // error flag sticky against a zero write, cleared by a one (R9)
    bus_write(12'hC00, 32'h4);
    bus_read(12'hC00, rd);
    chk("R9 flag kept after write of 0", rd, 32'h104);
    bus_write(12'hC00, 32'h104);
    bus_read(12'hC00, rd);
    chk("R9 flag cleared by write of 1", rd, 32'h4);

    // blanking opens the window while enabled (R7)
    @(posedge clk); #1 vblank_i = 1'b1;
    bus_write(12'h014, 32'hFFFF_FF99);
    mdl[0][5] = 8'h99;
    bus_read(12'h014, rd);
    chk("R7 write and read during blanking", rd, 32'h99);
    bus_read(12'hC00, rd);
    chk("R7 no error during blanking", rd, 32'h4);
    drive_pix(8'd5, 8'd5, 8'd5, 1'b0, 1'b1, 1'b1);
    idle_pix();
    @(posedge clk); #1 vblank_i = 1'b0;
    drive_pix(8'd5, 8'd200, 8'd100, 1'b1, 1'b0, 1'b0);
    idle_pix();

    // correction off: access open without blanking, bypass again (R7, R2)
    bus_write(12'hC00, 32'h0);
    mdl_en = 0;
    bus_write(12'h808, 32'h3C);
    mdl[2][2] = 8'h3C;
    bus_read(12'h808, rd);
    chk("R7 access with correction off", rd, 32'h3C);
    drive_pix(8'd2, 8'd2, 8'd2, 1'b0, 1'b0, 1'b0);
    idle_pix();
    bus_write(12'hC00, 32'h4);
    mdl_en = 1;
    drive_pix(8'd2, 8'd2, 8'd2, 1'b1, 1'b1, 1'b0);
    idle_pix();

    chk("R4 all pixels produced", q.size(), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule